// File: doc/BRIEF.md
# Bus-Master DMA Channel Controller

This block is a register-programmed DMA channel placed beside a SCSI protocol core. Software programs a starting byte count, a starting physical address and a starting descriptor address, then writes a command. A start command loads the working count and address from the starting values and enables DMA toward the core. The core then asks for bursts with a direction and a byte length. The controller clips each burst to the bytes that remain, issues it on a simple request/grant memory port, and then steps the working count down and the working address up.

The controller keeps a six-bit status word (power-down, error, abort, done, SCSI interrupt, blast complete) and drives one level-sensitive interrupt line. Bit 24 of a separate bus-control register selects how status is cleared. When it is 0, a read of status returns the old value and then clears error, abort and done. When it is 1, software clears those bits by writing ones to them. The core's interrupt line is mirrored into status. If the core interrupts while a start is in force and no bytes remain, done is set in the same cycle.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the command, working count and status read 0, the working address reads 0xFFFFFFFF, the working descriptor address reads 0xFFFFFFFD, and `irq_o` and `core_dma_en_o` are 0.
- R2: Register addresses: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address, 7 working descriptor address, 8 bus control. Addresses 9 to 15 read 0. Writes to addresses 0, 1, 2, 6 and 8 are stored. Writes to addresses 3, 4 and 7 are ignored. `reg_rdata_o` shows the addressed register in the same cycle.
- R3: Command bits [1:0] select the operation: 0 idle, 1 blast, 2 abort, 3 start. Bit 6 enables the done interrupt. Bit 7 gives the direction (1 means device to memory). An idle write clears `core_dma_en_o` from the next cycle.
- R4: A start write copies the start count, start address and start descriptor address into their working registers. It clears status bits 5:0 and sets `core_dma_en_o` from the next cycle.
- R5: A blast write sets status bit 5 and changes nothing else.
- R6: With bus-control bit 24 at 0, writes to status are ignored. A read of status with `reg_rd_i` high returns the old value, and status bits 1, 2 and 3 are clear from the next cycle.
- R7: With bus-control bit 24 at 1, a status write clears only those of bits 1, 2 and 3 that are written as 1, and a status read has no side effect.
- R8: A rising edge of `core_irq_i` sets status bit 4. If the command field is start and the working count is 0, the same edge also sets bit 3. A falling edge clears bit 4.
- R9: `irq_o` equals status bit 4 OR (status bit 3 AND command bit 6).
- R10: While DMA is enabled, a burst whose direction matches command bit 7 is clipped to min(requested length, working count). It is issued on the memory port with the working address and `mem_wr_o` equal to bit 7. On grant, `brst_done_o` pulses with the clipped length, the working count falls by that length and the working address rises by it.
- R11: While DMA is enabled, a burst whose direction differs from command bit 7 completes at once with `brst_xfer_o` 0, issues no memory request and leaves the count and address unchanged.
- R12: While DMA is disabled, a burst request gets no completion and no memory request. It is served once a start command enables DMA.
- R13: A matching burst when the working count is 0 completes at once with length 0 and issues no memory request.
- R14: An abort write raises `core_cancel_o` for exactly the next cycle and leaves status and the DMA enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of addressed register |
| core_irq_i | input | 1 | Interrupt level from SCSI core |
| core_dma_en_o | output | 1 | DMA enabled toward core |
| core_cancel_o | output | 1 | One-cycle cancel pulse to core |
| brst_req_i | input | 1 | Burst request from core, held until done |
| brst_dir_i | input | 1 | Burst direction, 1 device to memory |
| brst_len_i | input | 16 | Requested burst length in bytes |
| brst_done_o | output | 1 | Burst finished this cycle |
| brst_xfer_o | output | 16 | Bytes moved by the finished burst |
| mem_req_o | output | 1 | Memory request |
| mem_gnt_i | input | 1 | Memory grant, completes the burst |
| mem_adr_o | output | 32 | Memory byte address |
| mem_len_o | output | 16 | Memory burst length |
| mem_wr_o | output | 1 | 1 writes memory, 0 reads memory |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench compares the design each cycle against a behavioural model. It also runs directed cases for the corners that break easily. A burst longer than the remaining count must be clipped; a design that does not clip would drive the working count below zero. A burst in the wrong direction must complete without touching the counters; one that is not dropped would move data or corrupt the address. A burst that arrives while DMA is disabled must wait; one that does not would transfer before a start. The bench exercises both status-clear modes. A design that confused them would either clear done on a write in read-clear mode or lose done on a harmless read. It also raises the core interrupt with a zero count to catch a design that fails to force done, or that fails to drop the interrupt when the done enable is off.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  typedef enum logic {BS_IDLE, BS_MEM} bst_e;

  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] RI_CMD  = 4'd0;
  localparam logic [REG_AW-1:0] RI_SCNT = 4'd1;
  localparam logic [REG_AW-1:0] RI_SADR = 4'd2;
  localparam logic [REG_AW-1:0] RI_WCNT = 4'd3;
  localparam logic [REG_AW-1:0] RI_WADR = 4'd4;
  localparam logic [REG_AW-1:0] RI_STAT = 4'd5;
  localparam logic [REG_AW-1:0] RI_SDSC = 4'd6;
  localparam logic [REG_AW-1:0] RI_WDSC = 4'd7;
  localparam logic [REG_AW-1:0] RI_BCTL = 4'd8;

  localparam int ST_W    = 6;
  localparam int ST_DONE = 3;
  localparam int ST_SINT = 4;
  localparam int ST_BLST = 5;
  localparam logic [ST_W-1:0] ST_CLR_EVT = 6'b001110; // error, abort, done

  localparam int CB_DONE_IE = 6;
  localparam int CB_DIR     = 7;
endpackage

// File: rtl/dma_stat_unit.sv
module dma_stat_unit
  import dma_chan_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            core_irq_i,
  input  logic            start_i,
  input  logic            blast_i,
  input  logic            rd_clr_i,
  input  logic            wr_clr_i,
  input  logic [ST_W-1:0] wr_mask_i,
  input  logic            run_op_i,
  input  logic            wcnt_zero_i,
  input  logic            done_ie_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  logic            irq_q;
  logic            rise, fall, done_set;
  logic [ST_W-1:0] clr, set, stat_q;

  assign rise     = core_irq_i & ~irq_q;
  assign fall     = ~core_irq_i & irq_q;
  assign done_set = rise & run_op_i & wcnt_zero_i;

  always_comb begin
    clr = '0;
    if (start_i)  clr = '1;
    if (fall)     clr[ST_SINT] = 1'b1;
    if (rd_clr_i) clr = clr | ST_CLR_EVT;
    if (wr_clr_i) clr = clr | (wr_mask_i & ST_CLR_EVT);
    set = '0;
    set[ST_SINT] = rise;
    set[ST_DONE] = done_set;
    set[ST_BLST] = blast_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | set;
      irq_q  <= core_irq_i;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q[ST_SINT] | (stat_q[ST_DONE] & done_ie_i);

  a_r8_fall_clears_sint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !core_irq_i) |=> !stat_q[ST_SINT]);
  a_r8_rise_sets_sint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && core_irq_i) |=> stat_q[ST_SINT]);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !done_set) |=> (stat_q[3:1] == 3'b000));
  a_r7_keep_unwritten_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !wr_mask_i[ST_DONE] && !start_i && stat_q[ST_DONE]) |=> stat_q[ST_DONE]);
endmodule

// File: rtl/dma_burst_eng.sv
module dma_burst_eng
  import dma_chan_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dir_cfg_i,
  input  logic [DW-1:0] wcnt_i,
  input  logic [DW-1:0] wadr_i,
  input  logic          req_i,
  input  logic          dir_i,
  input  logic [LW-1:0] len_i,
  input  logic          mem_gnt_i,
  output logic          done_o,
  output logic [LW-1:0] xfer_o,
  output logic          take_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_adr_o,
  output logic [LW-1:0] mem_len_o,
  output logic          mem_wr_o
);
  bst_e          st_q, st_d;
  logic [LW-1:0] clip, len_q;
  logic [DW-1:0] adr_q;
  logic          wr_q;

  assign clip = (wcnt_i < DW'(len_i)) ? wcnt_i[LW-1:0] : len_i;

  always_comb begin
    st_d   = st_q;
    done_o = 1'b0;
    xfer_o = '0;
    take_o = 1'b0;
    case (st_q)
      BS_IDLE: begin
        if (req_i && en_i) begin
          if (dir_i != dir_cfg_i || clip == '0) done_o = 1'b1;
          else st_d = BS_MEM;
        end
      end
      BS_MEM: begin
        if (mem_gnt_i) begin
          done_o = 1'b1;
          xfer_o = len_q;
          take_o = 1'b1;
          st_d   = BS_IDLE;
        end
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BS_IDLE;
      len_q <= '0;
      adr_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == BS_IDLE && st_d == BS_MEM) begin
        len_q <= clip;
        adr_q <= wadr_i;
        wr_q  <= dir_cfg_i;
      end
    end
  end

  assign mem_req_o = (st_q == BS_MEM);
  assign mem_adr_o = adr_q;
  assign mem_len_o = len_q;
  assign mem_wr_o  = wr_q;

  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_adr_o) && $stable(mem_len_o)));
  a_r12_no_req_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_IDLE && !en_i) |=> !mem_req_o);
  a_r11_drop_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_IDLE && req_i && en_i && dir_i != dir_cfg_i) |=> !mem_req_o);
  a_r13_nonzero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o != '0));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DW       = 32,
  parameter int LW       = 16,
  parameter int MODE_BIT = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              core_irq_i,
  output logic              core_dma_en_o,
  output logic              core_cancel_o,
  input  logic              brst_req_i,
  input  logic              brst_dir_i,
  input  logic [LW-1:0]     brst_len_i,
  output logic              brst_done_o,
  output logic [LW-1:0]     brst_xfer_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [DW-1:0]     mem_adr_o,
  output logic [LW-1:0]     mem_len_o,
  output logic              mem_wr_o,
  output logic              irq_o
);
  localparam logic [DW-1:0] WADR_RST = '1;
  localparam logic [DW-1:0] WDSC_RST = ~DW'(2);

  logic [DW-1:0]   cmd_q, scnt_q, sadr_q, wcnt_q, wadr_q, sdsc_q, wdsc_q, bctl_q;
  logic            en_q, cancel_q;
  logic            wr_cmd, start_w, idle_w, blast_w, abort_w;
  logic            clr_mode, rd_clr, wr_clr, take;
  logic [ST_W-1:0] stat;
  dma_op_e         op;

  assign op       = dma_op_e'(reg_wdata_i[1:0]);
  assign wr_cmd   = reg_wr_i && (reg_addr_i == RI_CMD);
  assign start_w  = wr_cmd && (op == OP_START);
  assign idle_w   = wr_cmd && (op == OP_IDLE);
  assign blast_w  = wr_cmd && (op == OP_BLAST);
  assign abort_w  = wr_cmd && (op == OP_ABORT);
  assign clr_mode = bctl_q[MODE_BIT];
  assign rd_clr   = reg_rd_i && (reg_addr_i == RI_STAT) && !clr_mode;
  assign wr_clr   = reg_wr_i && (reg_addr_i == RI_STAT) && clr_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      scnt_q   <= '0;
      sadr_q   <= '0;
      wcnt_q   <= '0;
      wadr_q   <= WADR_RST;
      sdsc_q   <= '0;
      wdsc_q   <= WDSC_RST;
      bctl_q   <= '0;
      en_q     <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        case (reg_addr_i)
          RI_CMD:  cmd_q  <= reg_wdata_i;
          RI_SCNT: scnt_q <= reg_wdata_i;
          RI_SADR: sadr_q <= reg_wdata_i;
          RI_SDSC: sdsc_q <= reg_wdata_i;
          RI_BCTL: bctl_q <= reg_wdata_i;
          default: ;
        endcase
      end
      if (start_w) begin
        wcnt_q <= scnt_q;
        wadr_q <= sadr_q;
        wdsc_q <= sdsc_q;
      end else if (take) begin
        wcnt_q <= wcnt_q - DW'(brst_xfer_o);
        wadr_q <= wadr_q + DW'(brst_xfer_o);
      end
      if (start_w)     en_q <= 1'b1;
      else if (idle_w) en_q <= 1'b0;
      cancel_q <= abort_w;
    end
  end

  always_comb begin
    case (reg_addr_i)
      RI_CMD:  reg_rdata_o = cmd_q;
      RI_SCNT: reg_rdata_o = scnt_q;
      RI_SADR: reg_rdata_o = sadr_q;
      RI_WCNT: reg_rdata_o = wcnt_q;
      RI_WADR: reg_rdata_o = wadr_q;
      RI_STAT: reg_rdata_o = DW'(stat);
      RI_SDSC: reg_rdata_o = sdsc_q;
      RI_WDSC: reg_rdata_o = wdsc_q;
      RI_BCTL: reg_rdata_o = bctl_q;
      default: reg_rdata_o = '0;
    endcase
  end

  dma_stat_unit u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_irq_i  (core_irq_i),
    .start_i     (start_w),
    .blast_i     (blast_w),
    .rd_clr_i    (rd_clr),
    .wr_clr_i    (wr_clr),
    .wr_mask_i   (reg_wdata_i[ST_W-1:0]),
    .run_op_i    (cmd_q[1:0] == OP_START),
    .wcnt_zero_i (wcnt_q == '0),
    .done_ie_i   (cmd_q[CB_DONE_IE]),
    .stat_o      (stat),
    .irq_o       (irq_o)
  );

  dma_burst_eng #(.DW(DW), .LW(LW)) u_brst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .dir_cfg_i (cmd_q[CB_DIR]),
    .wcnt_i    (wcnt_q),
    .wadr_i    (wadr_q),
    .req_i     (brst_req_i),
    .dir_i     (brst_dir_i),
    .len_i     (brst_len_i),
    .mem_gnt_i (mem_gnt_i),
    .done_o    (brst_done_o),
    .xfer_o    (brst_xfer_o),
    .take_o    (take),
    .mem_req_o (mem_req_o),
    .mem_adr_o (mem_adr_o),
    .mem_len_o (mem_len_o),
    .mem_wr_o  (mem_wr_o)
  );

  assign core_dma_en_o = en_q;
  assign core_cancel_o = cancel_q;

  a_r4_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (wcnt_q == $past(scnt_q) && wadr_q == $past(sadr_q)
                 && wdsc_q == $past(sdsc_q) && core_dma_en_o));
  a_r3_idle_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_w |=> !core_dma_en_o);
  a_r2_wcnt_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == RI_WCNT && !take) |=> $stable(wcnt_q));
  a_r10_count_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !start_w) |=> (wcnt_q == $past(wcnt_q) - DW'($past(brst_xfer_o))));
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic        core_irq = 1'b0;
  logic        dma_en, cancel;
  logic        brst_req = 1'b0, brst_dir = 1'b0;
  logic [15:0] brst_len = '0;
  logic        brst_done;
  logic [15:0] brst_xfer;
  logic        mem_req, mem_gnt = 1'b0, mem_wr, irq;
  logic [31:0] mem_adr;
  logic [15:0] mem_len;

  int n_chk = 0, n_fail = 0, gnt_lat = 1, wait_cnt = 0;

  always #10 clk = ~clk;

  dma_chan_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .core_irq_i(core_irq), .core_dma_en_o(dma_en), .core_cancel_o(cancel),
    .brst_req_i(brst_req), .brst_dir_i(brst_dir), .brst_len_i(brst_len),
    .brst_done_o(brst_done), .brst_xfer_o(brst_xfer), .mem_req_o(mem_req),
    .mem_gnt_i(mem_gnt), .mem_adr_o(mem_adr), .mem_len_o(mem_len),
    .mem_wr_o(mem_wr), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_cmd, m_scnt, m_sadr, m_wcnt, m_wadr, m_sdsc, m_wdsc, m_bctl;
  logic [5:0]  m_stat;
  logic        m_en, m_cancel, m_irqq, m_busy, m_bwr;
  logic [15:0] m_blen;
  logic [31:0] m_badr;

  function automatic logic [31:0] m_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_cmd;   4'd1: return m_scnt;  4'd2: return m_sadr;
      4'd3: return m_wcnt;  4'd4: return m_wadr;  4'd5: return {26'b0, m_stat};
      4'd6: return m_sdsc;  4'd7: return m_wdsc;  4'd8: return m_bctl;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_clip();
    return (m_wcnt < {16'b0, brst_len}) ? m_wcnt : {16'b0, brst_len};
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic rise, fall, take, wcmd, mode;
    logic [5:0] clr, sset;
    logic [31:0] cv;
    if (!rst_n) begin
      m_cmd = 0; m_scnt = 0; m_sadr = 0; m_wcnt = 0; m_wadr = 32'hFFFF_FFFF;
      m_sdsc = 0; m_wdsc = 32'hFFFF_FFFD; m_bctl = 0; m_stat = 0; m_en = 0;
      m_cancel = 0; m_irqq = 0; m_busy = 0; m_bwr = 0; m_blen = 0; m_badr = 0;
    end else begin
      wcmd = reg_wr && reg_addr == 4'd0;
      mode = m_bctl[24];
      rise = core_irq && !m_irqq;
      fall = !core_irq && m_irqq;
      clr = 0; sset = 0;
      if (wcmd && reg_wdata[1:0] == 2'd3) clr = 6'h3F;
      if (fall) clr[4] = 1;
      if (reg_rd && reg_addr == 4'd5 && !mode) clr = clr | 6'h0E;
      if (reg_wr && reg_addr == 4'd5 && mode) clr = clr | (reg_wdata[5:0] & 6'h0E);
      if (rise) sset[4] = 1;
      if (rise && m_cmd[1:0] == 2'd3 && m_wcnt == 0) sset[3] = 1;
      if (wcmd && reg_wdata[1:0] == 2'd1) sset[5] = 1;
      m_stat = (m_stat & ~clr) | sset;
      take = 0;
      if (!m_busy) begin
        cv = m_clip();
        if (brst_req && m_en && brst_dir == m_cmd[7] && cv != 0) begin
          m_busy = 1; m_blen = cv[15:0]; m_badr = m_wadr; m_bwr = m_cmd[7];
        end
      end else if (mem_gnt) begin
        take = 1; m_busy = 0;
      end
      if (wcmd && reg_wdata[1:0] == 2'd3) begin
        m_wcnt = m_scnt; m_wadr = m_sadr; m_wdsc = m_sdsc; m_en = 1;
      end else begin
        if (take) begin m_wcnt = m_wcnt - m_blen; m_wadr = m_wadr + m_blen; end
        if (wcmd && reg_wdata[1:0] == 2'd0) m_en = 0;
      end
      m_cancel = wcmd && reg_wdata[1:0] == 2'd2;
      if (reg_wr) begin
        case (reg_addr)
          4'd0: m_cmd = reg_wdata;  4'd1: m_scnt = reg_wdata;
          4'd2: m_sadr = reg_wdata; 4'd6: m_sdsc = reg_wdata;
          4'd8: m_bctl = reg_wdata;
          default: ;
        endcase
      end
      m_irqq = core_irq;
    end
  end

  // per-cycle comparison, away from the active edge
  always begin : compare
    logic e_done;
    logic [31:0] cv;
    @(negedge clk); #5;
    if (rst_n) begin
      cv = m_clip();
      e_done = (!m_busy && brst_req && m_en && (brst_dir != m_cmd[7] || cv == 0))
               || (m_busy && mem_gnt);
      chk("R2 rdata", rdata, m_rd(reg_addr));
      chk("R9 irq_o", {31'b0, irq}, {31'b0, m_stat[4] | (m_stat[3] & m_cmd[6])});
      chk("R3 dma_en", {31'b0, dma_en}, {31'b0, m_en});
      chk("R14 cancel", {31'b0, cancel}, {31'b0, m_cancel});
      chk("R10 mem_req", {31'b0, mem_req}, {31'b0, m_busy});
      chk("R10 brst_done", {31'b0, brst_done}, {31'b0, e_done});
      if (m_busy) begin
        chk("R10 mem_adr", mem_adr, m_badr);
        chk("R10 mem_len", {16'b0, mem_len}, {16'b0, m_blen});
        chk("R10 mem_wr", {31'b0, mem_wr}, {31'b0, m_bwr});
      end
      if (e_done)
        chk("R10 brst_xfer", {16'b0, brst_xfer}, (m_busy && mem_gnt) ? {16'b0, m_blen} : 32'h0);
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (mem_req && !mem_gnt) begin
      if (wait_cnt >= gnt_lat) mem_gnt = 1'b1;
      else wait_cnt++;
    end else begin
      mem_gnt = 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #5 d = rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    #5 d = rdata;
  endtask

  task automatic wait_done(output logic [15:0] x, output logic sm, output logic swr);
    logic got;
    got = 0; sm = 0; swr = 0; x = '1;
    for (int i = 0; i < 40 && !got; i++) begin
      #5;
      if (mem_req) begin sm = 1; swr = mem_wr; end
      if (brst_done) begin got = 1; x = brst_xfer; end
      @(negedge clk);
    end
    brst_req = 1'b0;
    if (!got) chk("R10 burst completion", 32'h0, 32'h1);
  endtask

  task automatic burst(input logic d, input logic [15:0] l,
                       output logic [15:0] x, output logic sm, output logic swr);
    @(negedge clk); brst_req = 1'b1; brst_dir = d; brst_len = l;
    wait_done(x, sm, swr);
  endtask

  task automatic pulse_irq();
    @(negedge clk); core_irq = 1'b1;
    @(negedge clk); core_irq = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] x;
    logic sm, swr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(4'd0, v); chk("R1 cmd", v, 32'h0);
    peek(4'd3, v); chk("R1 wcnt", v, 32'h0);
    peek(4'd4, v); chk("R1 wadr", v, 32'hFFFF_FFFF);
    peek(4'd5, v); chk("R1 stat", v, 32'h0);
    peek(4'd7, v); chk("R1 wdsc", v, 32'hFFFF_FFFD);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 dma_en", {31'b0, dma_en}, 32'h0);

    // R2 writable and read-only registers
    reg_write(4'd1, 32'h40); reg_write(4'd2, 32'h1000); reg_write(4'd6, 32'h2000);
    reg_write(4'd3, 32'h55); reg_write(4'd4, 32'h77); reg_write(4'd7, 32'h99);
    peek(4'd1, v); chk("R2 scnt", v, 32'h40);
    peek(4'd2, v); chk("R2 sadr", v, 32'h1000);
    peek(4'd6, v); chk("R2 sdsc", v, 32'h2000);
    peek(4'd3, v); chk("R2 wcnt ignored", v, 32'h0);
    peek(4'd4, v); chk("R2 wadr ignored", v, 32'hFFFF_FFFF);
    peek(4'd7, v); chk("R2 wdsc ignored", v, 32'hFFFF_FFFD);
    peek(4'd12, v); chk("R2 unmapped", v, 32'h0);
    reg_write(4'd8, 32'h0100_0000);
    peek(4'd8, v); chk("R2 bctl", v, 32'h0100_0000);

    // R5 blast
    reg_write(4'd0, 32'h01);
    peek(4'd5, v); chk("R5 blast status", v, 32'h20);
    chk("R5 enable unchanged", {31'b0, dma_en}, 32'h0);

    // R4 start
    reg_write(4'd0, 32'h83);
    peek(4'd5, v); chk("R4 status cleared", v, 32'h0);
    peek(4'd3, v); chk("R4 wcnt", v, 32'h40);
    peek(4'd4, v); chk("R4 wadr", v, 32'h1000);
    peek(4'd7, v); chk("R4 wdsc", v, 32'h2000);
    chk("R4 enabled", {31'b0, dma_en}, 32'h1);

    // R10 plain burst
    gnt_lat = 2;
    burst(1'b1, 16'h10, x, sm, swr);
    chk("R10 xfer", {16'b0, x}, 32'h10);
    chk("R10 mem used", {31'b0, sm}, 32'h1);
    chk("R10 mem write dir", {31'b0, swr}, 32'h1);
    peek(4'd3, v); chk("R10 wcnt", v, 32'h30);
    peek(4'd4, v); chk("R10 wadr", v, 32'h1010);

    // R11 direction mismatch
    burst(1'b0, 16'h08, x, sm, swr);
    chk("R11 xfer zero", {16'b0, x}, 32'h0);
    chk("R11 no mem", {31'b0, sm}, 32'h0);
    peek(4'd3, v); chk("R11 wcnt kept", v, 32'h30);
    peek(4'd4, v); chk("R11 wadr kept", v, 32'h1010);

    // R10 clipped burst
    gnt_lat = 0;
    burst(1'b1, 16'h50, x, sm, swr);
    chk("R10 clipped xfer", {16'b0, x}, 32'h30);
    peek(4'd3, v); chk("R10 wcnt zero", v, 32'h0);
    peek(4'd4, v); chk("R10 wadr end", v, 32'h1040);

    // R13 zero remaining
    burst(1'b1, 16'h08, x, sm, swr);
    chk("R13 xfer zero", {16'b0, x}, 32'h0);
    chk("R13 no mem", {31'b0, sm}, 32'h0);

    // R8 core interrupt with zero count under start
    @(negedge clk); core_irq = 1'b1;
    peek(4'd5, v); chk("R8 sint and done", v, 32'h18);
    chk("R9 irq from sint", {31'b0, irq}, 32'h1);
    @(negedge clk); core_irq = 1'b0;
    peek(4'd5, v); chk("R8 fall clears sint", v, 32'h08);
    chk("R9 done without enable", {31'b0, irq}, 32'h0);

    // R7 write-one-to-clear mode
    reg_read(4'd5, v); chk("R7 read value", v, 32'h08);
    peek(4'd5, v); chk("R7 read no clear", v, 32'h08);
    reg_write(4'd5, 32'h06);
    peek(4'd5, v); chk("R7 unwritten done kept", v, 32'h08);
    reg_write(4'd5, 32'h08);
    peek(4'd5, v); chk("R7 done cleared", v, 32'h0);

    // R9 done interrupt enable
    reg_write(4'd1, 32'h0);
    reg_write(4'd0, 32'hC3);
    pulse_irq();
    peek(4'd5, v); chk("R8 done forced", v, 32'h08);
    chk("R9 irq from done", {31'b0, irq}, 32'h1);
    reg_write(4'd5, 32'h08);
    peek(4'd5, v); chk("R9 cleared status", v, 32'h0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);

    // R6 clear-on-read mode
    reg_write(4'd8, 32'h0);
    pulse_irq();
    peek(4'd5, v); chk("R6 done set", v, 32'h08);
    reg_write(4'd5, 32'hFF);
    peek(4'd5, v); chk("R6 write ignored", v, 32'h08);
    reg_read(4'd5, v); chk("R6 old value", v, 32'h08);
    peek(4'd5, v); chk("R6 cleared on read", v, 32'h0);
    chk("R6 irq low", {31'b0, irq}, 32'h0);

    // R14 abort
    reg_write(4'd0, 32'h02);
    #5 chk("R14 cancel pulse", {31'b0, cancel}, 32'h1);
    chk("R14 enable kept", {31'b0, dma_en}, 32'h1);
    @(negedge clk); #5 chk("R14 cancel one cycle", {31'b0, cancel}, 32'h0);
    peek(4'd5, v); chk("R14 status kept", v, 32'h0);

    // R3 idle, R12 hold-off
    reg_write(4'd1, 32'h20);
    reg_write(4'd0, 32'h80);
    #5 chk("R3 idle disables", {31'b0, dma_en}, 32'h0);
    @(negedge clk); brst_req = 1'b1; brst_dir = 1'b1; brst_len = 16'h08;
    for (int i = 0; i < 4; i++) begin
      #5;
      chk("R12 no done while disabled", {31'b0, brst_done}, 32'h0);
      chk("R12 no mem while disabled", {31'b0, mem_req}, 32'h0);
      @(negedge clk);
    end
    reg_write(4'd0, 32'h83);
    wait_done(x, sm, swr);
    chk("R12 served after start", {16'b0, x}, 32'h08);
    peek(4'd3, v); chk("R12 wcnt", v, 32'h18);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule